// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

This block divides a 32.768 kHz time-base enable through a 15-stage binary chain. A 4-bit rate code picks one stage of that chain. The chosen stage feeds two consumers. The first is a square-wave pin, which has its own enable. The second is a one-cycle periodic event pulse for the interrupt logic. The same chain also gives a one-pulse-per-second tick for the calendar counters.

A 3-bit oscillator-control code sets the chain's state. Code 010 lets the chain count. Codes 110 and 111 hold the chain at zero. Every other code stops the oscillator, and the chain then keeps its count without advancing. In both non-running states the block produces no square wave and no pulses.

Everything runs on the system clock. The time base arrives as a single-cycle enable, not as a second clock.

Top module: `rate_sqw_gen`

## Requirements
- R1: While reset is low and after it is released, `sqw_out`, `per_pulse` and `sec_tick` are 0 and the divider count is zero. The first `sec_tick` comes after exactly 32768 counted steps.
- R2: With `osc_ctl` = 3'b010, the divider advances by one on every clock in which `tb_en` is 1. It does not advance in any other clock.
- R3: With `osc_ctl` = 3'b110 or 3'b111, the divider is forced to zero and all three outputs are 0. Counting restarts from zero once 3'b010 returns.
- R4: With any `osc_ctl` code other than 010, 110 or 111, the divider keeps its count and all three outputs are 0. Counting resumes from the kept count.
- R5: `rate_sel` = 1 selects 256 Hz (stage 6) and `rate_sel` = 2 selects 128 Hz (stage 7). Stage n of the chain toggles at 32768 / 2^(n+1) Hz.
- R6: `rate_sel` values 3 through 15 select 8192 Hz down to 2 Hz, halving at each step. This is stage `rate_sel` − 2.
- R7: `rate_sel` = 0 keeps `sqw_out` and `per_pulse` at 0.
- R8: `per_pulse` is high for exactly one clock on each 0-to-1 transition of the selected stage. This holds whatever the value of `sqw_en`.
- R9: `sqw_out` follows the selected stage while `sqw_en` is 1 and the chain runs. It is 0 while `sqw_en` is 0.
- R10: `sec_tick` is high for one clock each time the 15-stage chain wraps from all ones to zero, which is once every 32768 steps. It does not depend on `rate_sel`.
- R11: All outputs are registered. Each output reflects the inputs of the clock edge that precedes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tb_en | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| osc_ctl | input | 3 | Oscillator and chain control code |
| rate_sel | input | 4 | Rate/tap select code |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_out | output | 1 | Gated square wave |
| per_pulse | output | 1 | One-cycle periodic event to the interrupt logic |
| sec_tick | output | 1 | One-cycle 1 Hz tick to the clock counters |

## Verification
All three outputs are due one clock after the edge that samples the inputs: a stimulus driven on a falling edge shows up on the outputs just after the next rising edge. The driver task runs an independent frequency-to-stage model. For every cycle it drives, it pushes one expected output triple into a queue. The monitor pops one triple a few nanoseconds after each rising edge, so each comparison lands in the exact cycle that the one-register latency calls for. After a reset, the bench waits out the two-cycle reset synchronizer before it starts pushing expectations again.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_RUN  = 2'd1,
    CH_HOLD = 2'd2
  } chain_mode_e;

  localparam logic [2:0] CTL_RUN_CODE = 3'b010;

endpackage

// File: rtl/rsg_mode_dec.sv
module rsg_mode_dec
  import rsg_pkg::*;
#(
  parameter int CTL_W = 3
) (
  input  logic [CTL_W-1:0] osc_ctl,
  output chain_mode_e      mode
);

  always_comb begin
    if (osc_ctl == CTL_W'(CTL_RUN_CODE)) begin
      mode = CH_RUN;
    end else if (osc_ctl[CTL_W-1:CTL_W-2] == 2'b11) begin
      mode = CH_HOLD;
    end else begin
      mode = CH_OFF;
    end
  end

endmodule

// File: rtl/rsg_divider.sv
module rsg_divider
  import rsg_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              tb_en,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] cnt_q,
  output logic [STAGES-1:0] cnt_nxt,
  output logic              step_go,
  output logic              sec_tick
);

  logic sec_d;

  always_comb begin
    step_go = (mode == CH_RUN) && tb_en;
    unique case (mode)
      CH_RUN:  cnt_nxt = step_go ? cnt_q + STAGES'(1) : cnt_q;
      CH_HOLD: cnt_nxt = '0;
      default: cnt_nxt = cnt_q;
    endcase
    sec_d = step_go && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      sec_tick <= sec_d;
    end
  end

  AST_RUN_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == CH_RUN && tb_en) |=> (cnt_q == $past(cnt_q) + STAGES'(1))); // R2

  AST_HOLD_CLEARS_CHAIN: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == CH_HOLD) |=> (cnt_q == '0)); // R3

  AST_OFF_FREEZES_CHAIN: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode == CH_OFF) |=> $stable(cnt_q)); // R4

  AST_SEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    sec_tick |=> !sec_tick); // R10

endmodule

// File: rtl/rsg_tap_sel.sv
module rsg_tap_sel
  import rsg_pkg::*;
#(
  parameter int STAGES       = 15,
  parameter int RS_W         = 4,
  parameter int FAST_RS_BASE = 3,
  parameter int ALT1_TAP     = 6,
  parameter int ALT2_TAP     = 7
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  chain_mode_e       mode,
  input  logic              step_go,
  input  logic [STAGES-1:0] cnt_q,
  input  logic [STAGES-1:0] cnt_nxt,
  input  logic [RS_W-1:0]   rate_sel,
  input  logic              sqw_en,
  output logic              sqw_out,
  output logic              per_pulse
);

  localparam int K_W = $clog2(STAGES);

  logic [K_W-1:0]    tap_k;
  logic              tap_valid;
  logic [STAGES-1:0] low_mask;
  logic [STAGES-1:0] rise_pat;
  logic              tap_nxt;
  logic              sqw_d;
  logic              per_d;

  // Rate code to chain stage
  always_comb begin
    tap_valid = (rate_sel != '0);
    if (rate_sel == RS_W'(1)) begin
      tap_k = K_W'(ALT1_TAP);
    end else if (rate_sel == RS_W'(2)) begin
      tap_k = K_W'(ALT2_TAP);
    end else begin
      tap_k = K_W'(rate_sel) - K_W'(FAST_RS_BASE - 1);
    end
  end

  // Rising-edge pattern: stages below the tap all ones, the tap itself zero
  always_comb begin
    tap_nxt = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      low_mask[i] = (K_W'(i) <= tap_k);
      rise_pat[i] = (K_W'(i) <  tap_k);
      if (K_W'(i) == tap_k) begin
        tap_nxt = cnt_nxt[i];
      end
    end
    per_d = step_go && tap_valid && ((cnt_q & low_mask) == rise_pat);
    sqw_d = (mode == CH_RUN) && tap_valid && sqw_en && tap_nxt;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sqw_out   <= 1'b0;
      per_pulse <= 1'b0;
    end else begin
      sqw_out   <= sqw_d;
      per_pulse <= per_d;
    end
  end

  AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    per_pulse |=> !per_pulse); // R8

  AST_RATE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (rate_sel == '0) |=> (!sqw_out && !per_pulse)); // R7

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_sn)
    !sqw_en |=> !sqw_out); // R9

endmodule

// File: rtl/rate_sqw_gen.sv
module rate_sqw_gen
  import rsg_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RS_W   = 4,
  parameter int CTL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic [CTL_W-1:0] osc_ctl,
  input  logic [RS_W-1:0]  rate_sel,
  input  logic             sqw_en,
  output logic             sqw_out,
  output logic             per_pulse,
  output logic             sec_tick
);

  logic              rst_meta;
  logic              rst_sn;
  chain_mode_e       mode;
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_nxt;
  logic              step_go;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  rsg_mode_dec #(.CTL_W(CTL_W)) u_mode (
    .osc_ctl (osc_ctl),
    .mode    (mode)
  );

  rsg_divider #(.STAGES(STAGES)) u_div (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .tb_en    (tb_en),
    .mode     (mode),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .step_go  (step_go),
    .sec_tick (sec_tick)
  );

  rsg_tap_sel #(.STAGES(STAGES), .RS_W(RS_W)) u_tap (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .mode      (mode),
    .step_go   (step_go),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .rate_sel  (rate_sel),
    .sqw_en    (sqw_en),
    .sqw_out   (sqw_out),
    .per_pulse (per_pulse)
  );

  AST_IDLE_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode != CH_RUN) |=> (!sqw_out && !per_pulse && !sec_tick)); // R3 R4

  always_comb begin
    if (!rst_n) begin
      AST_RESET_OUTPUTS_LOW: assert (!sqw_out && !per_pulse && !sec_tick); // R1
    end
  end

endmodule

// File: tb/rate_sqw_gen_tb.sv
module rate_sqw_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_en;
  logic [2:0] osc_ctl;
  logic [3:0] rate_sel;
  logic       sqw_en;
  logic       sqw_out, per_pulse, sec_tick;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int ref_cnt;
  logic [2:0] exp_q[$];

  always #5 clk = ~clk;

  rate_sqw_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .osc_ctl(osc_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en),
    .sqw_out(sqw_out), .per_pulse(per_pulse), .sec_tick(sec_tick)
  );

  function automatic int tap_of(input int rs);
    int f;
    if (rs == 1)      f = 256;   // R5
    else if (rs == 2) f = 128;   // R5
    else              f = 8192 >> (rs - 3);  // R6
    return $clog2(32768 / f) - 1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus, expected outputs pushed for the next edge
  task automatic drive(input bit step, input logic [2:0] ctl, input int rs, input bit en);
    int  old_c, new_c, k;
    bit  run, hold, per, sec, sqw;
    @(negedge clk);
    tb_en = step; osc_ctl = ctl; rate_sel = 4'(rs); sqw_en = en;
    run  = (ctl == 3'b010);
    hold = (ctl[2:1] == 2'b11);
    old_c = ref_cnt;
    if (run)       new_c = step ? (old_c + 1) % 32768 : old_c;   // R2
    else if (hold) new_c = 0;                                   // R3
    else           new_c = old_c;                               // R4
    k   = (rs != 0) ? tap_of(rs) : 0;
    per = run && step && (rs != 0) && !old_c[k] && new_c[k];    // R8 R7
    sec = run && step && (old_c == 32767);                      // R10
    sqw = run && (rs != 0) && en && new_c[k];                   // R9
    ref_cnt = new_c;
    exp_q.push_back({sqw, per, sec});
  endtask

  // Monitor: outputs are due one clock after the sampling edge (R11)
  initial begin
    logic [2:0] e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check("R9 sqw_out (R11)",   sqw_out,   e[2]);
        check("R8 per_pulse (R11)", per_pulse, e[1]);
        check("R10 sec_tick (R11)", sec_tick,  e[0]);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tb_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset sqw_out",   sqw_out,   1'b0);
    check("R1 reset per_pulse", per_pulse, 1'b0);
    check("R1 reset sec_tick",  sec_tick,  1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ref_cnt = 0;
  endtask

  initial begin
    rst_n = 1'b0; tb_en = 1'b0; osc_ctl = 3'b010; rate_sel = 4'd3; sqw_en = 1'b1;
    ref_cnt = 0;
    do_reset();

    // R6 R8 R9: fastest rate, step every cycle
    for (int i = 0; i < 200; i++) drive(1, 3'b010, 3, 1);
    // R5: 256 Hz with alternating steps
    for (int i = 0; i < 600; i++) drive(i % 2 == 0, 3'b010, 1, 1);
    // R5 R8 R9: 128 Hz, square wave disabled, pulses continue
    for (int i = 0; i < 600; i++) drive(1, 3'b010, 2, 0);
    // R7: rate code zero
    for (int i = 0; i < 100; i++) drive(1, 3'b010, 0, 1);
    // R6: sweep slower rates
    for (int rs = 4; rs < 16; rs++)
      for (int i = 0; i < 300; i++) drive(1, 3'b010, rs, 1);
    // R4: oscillator off codes keep the count, then resume
    for (int i = 0; i < 50; i++) drive(1, 3'b000, 3, 1);
    for (int i = 0; i < 50; i++) drive(1, 3'b101, 3, 1);
    for (int i = 0; i < 40; i++) drive(1, 3'b010, 3, 1);
    // R3: hold codes clear the chain, then restart from zero
    for (int i = 0; i < 20; i++) drive(1, 3'b110, 3, 1);
    for (int i = 0; i < 20; i++) drive(1, 3'b111, 4, 1);
    for (int i = 0; i < 40; i++) drive(1, 3'b010, 3, 1);
    // R10 R6: two full seconds at 2 Hz
    for (int i = 0; i < 66000; i++) drive(1, 3'b010, 15, 1);
    // R1: reset mid-run, first tick after exactly 32768 steps
    for (int i = 0; i < 5; i++) drive(1, 3'b010, 3, 1);
    do_reset();
    for (int i = 0; i < 32800; i++) drive(1, 3'b010, 5, 0);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule